// File: doc/BRIEF.md
# Operator Console Sequencer

This block sits between the debounced operator keys of a small 12-bit word-addressed processor and the rest of that processor. It owns the program counter while the machine is halted. It turns single key presses into actions: loading an address, writing or reading one memory word, and starting or resuming execution. It keeps an address display and a data display current, so the operator sees what each access touched.

Writing and reading memory each take several cycles. A one-word request goes out on a valid/ready port, and the block waits there until the memory accepts it. Only after that does the program counter advance by one, so repeated presses walk through consecutive words. Start raises the run flag and gives a one-cycle pulse that tells the core to take its initial state. Continue raises the run flag with no pulse, and Stop drops it.

Two build options change key behaviour. One makes the write key act when it is released rather than when it is pressed. The other inverts the two single-step mode switches on their way to the core.

Top module: `panel_console`

## Requirements
- R1: After reset, run, core_init and mem_req_valid are 0, and pc, disp_addr and disp_data are 0.
- R2: The cycle after a Load press is seen, pc equals sw_reg.
- R3: A Deposit press issues a request with mem_req_write=1, address equal to pc and data equal to sw_reg. Valid, address, data and write are held unchanged until mem_req_ready is seen with valid.
- R4: An Examine press issues a request with mem_req_write=0 and address equal to pc. mem_rdata, sampled on the accepting cycle, appears on disp_data in the next cycle.
- R5: pc advances by one only in the cycle after a request is accepted, stays fixed while a request waits, and wraps from 7777 octal to 0.
- R6: Each press acts once, however many cycles the key stays held.
- R7: While a memory request is outstanding, Load, Deposit, Examine, Start and Continue presses are dropped.
- R8: A Start press while halted sets run to 1 and drives core_init high for exactly one cycle.
- R9: A Continue press while halted sets run to 1 and leaves core_init at 0.
- R10: Stop clears run at any time. While run is 1, Load, Deposit, Examine, Start and Continue presses have no effect.
- R11: step_mode and inst_mode follow their raw switches, inverted when INVERT_MODES=1. With DEP_ON_RELEASE=1, Deposit issues its request on key release and not on press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reg | input | 12 | Operator switch register |
| key_start | input | 1 | Start key level |
| key_load | input | 1 | Load Address key level |
| key_dep | input | 1 | Deposit key level |
| key_exam | input | 1 | Examine key level |
| key_cont | input | 1 | Continue key level |
| key_stop | input | 1 | Stop key level |
| sw_step_raw | input | 1 | Single-step switch, raw polarity |
| sw_inst_raw | input | 1 | Single-instruction switch, raw polarity |
| step_mode | output | 1 | Single-step mode to the core |
| inst_mode | output | 1 | Single-instruction mode to the core |
| run | output | 1 | Processor run flag |
| core_init | output | 1 | One-cycle pulse: clear accumulator, set link, reset sequencer, disable interrupts |
| pc | output | 12 | Program counter and its display |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 12 | Request address |
| mem_req_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, valid with mem_req_ready |
| disp_addr | output | 12 | Memory address display |
| disp_data | output | 12 | Memory data display |

## Verification
The bench writes a run of words with memory latency from zero to several cycles, then reloads the address and reads the words back. A design that advanced pc before acceptance, or moved the request while it waited, would return the wrong words. Keys are held for many cycles and pressed again during a long wait. An edge detector that repeats, or that does not block keys while busy, shows up as an extra memory request or a corrupted pc. Further cases cover the wrap at 7777 octal, keys pressed while running, the single-cycle width of the Start pulse, and a second instance built for release-triggered Deposit with inverted mode switches.

// File: rtl/panel_pkg.sv
package panel_pkg;
  localparam int KEY_START = 0;
  localparam int KEY_LOAD  = 1;
  localparam int KEY_DEP   = 2;
  localparam int KEY_EXAM  = 3;
  localparam int KEY_CONT  = 4;
  localparam int KEY_STOP  = 5;
  localparam int NUM_KEYS  = 6;

  typedef enum logic [0:0] {SEQ_IDLE, SEQ_WAIT} seq_state_t;
endpackage

// File: rtl/panel_key_edge.sv
module panel_key_edge #(
  parameter bit ON_RELEASE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic fire
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= level;
  end

  generate
    if (ON_RELEASE) begin : g_release
      assign fire = seen & ~level;
    end else begin : g_press
      assign fire = level & ~seen;
    end
  endgenerate
endmodule

// File: rtl/panel_run_ctl.sv
module panel_run_ctl (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic go_start,
  input  logic go_cont,
  input  logic go_stop,
  output logic run,
  output logic core_init
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      core_init <= 1'b0;
    end else begin
      core_init <= 1'b0;
      if (go_stop) begin
        run <= 1'b0;
      end else if (accept && go_start) begin
        run       <= 1'b1;
        core_init <= 1'b1;
      end else if (accept && go_cont) begin
        run <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_mem_seq.sv
module panel_mem_seq
  import panel_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_load,
  input  logic              go_dep,
  input  logic              go_exam,
  input  logic [WORD_W-1:0] sw_reg,
  output logic              idle,
  output logic [WORD_W-1:0] pc,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [WORD_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] disp_addr,
  output logic [WORD_W-1:0] disp_data
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  seq_state_t state;

  assign idle = (state == SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      pc        <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      disp_addr <= '0;
      disp_data <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (go_load) begin
            pc <= sw_reg;
          end else if (go_dep) begin
            req_valid <= 1'b1;
            req_write <= 1'b1;
            req_addr  <= pc;
            req_wdata <= sw_reg;
            disp_addr <= pc;
            disp_data <= sw_reg;
            state     <= SEQ_WAIT;
          end else if (go_exam) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_addr  <= pc;
            disp_addr <= pc;
            state     <= SEQ_WAIT;
          end
        end
        SEQ_WAIT: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            pc        <= pc + ONE;
            if (!req_write) disp_data <= rdata;
            state     <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/panel_console.sv
module panel_console
  import panel_pkg::*;
#(
  parameter int WORD_W         = 12,
  parameter bit DEP_ON_RELEASE = 1'b0,
  parameter bit INVERT_MODES   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sw_reg,
  input  logic              key_start,
  input  logic              key_load,
  input  logic              key_dep,
  input  logic              key_exam,
  input  logic              key_cont,
  input  logic              key_stop,
  input  logic              sw_step_raw,
  input  logic              sw_inst_raw,
  output logic              step_mode,
  output logic              inst_mode,
  output logic              run,
  output logic              core_init,
  output logic [WORD_W-1:0] pc,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [WORD_W-1:0] mem_req_addr,
  output logic [WORD_W-1:0] mem_req_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] disp_addr,
  output logic [WORD_W-1:0] disp_data
);
  logic [NUM_KEYS-1:0] levels;
  logic [NUM_KEYS-1:0] fire;
  logic                seq_idle;
  logic                accept;
  logic                quiet;

  always_comb begin
    levels            = '0;
    levels[KEY_START] = key_start;
    levels[KEY_LOAD]  = key_load;
    levels[KEY_DEP]   = key_dep;
    levels[KEY_EXAM]  = key_exam;
    levels[KEY_CONT]  = key_cont;
    levels[KEY_STOP]  = key_stop;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_KEYS; g++) begin : g_key
      localparam bit REL = (g == KEY_DEP) ? DEP_ON_RELEASE : 1'b0;
      panel_key_edge #(.ON_RELEASE(REL)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .level(levels[g]),
        .fire (fire[g])
      );
    end
  endgenerate

  // Keys act only while halted and idle; run-control keys win over access keys.
  assign accept = ~run & seq_idle;
  assign quiet  = ~(fire[KEY_START] | fire[KEY_CONT] | fire[KEY_STOP]);

  panel_run_ctl u_run (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .go_start (fire[KEY_START]),
    .go_cont  (fire[KEY_CONT]),
    .go_stop  (fire[KEY_STOP]),
    .run      (run),
    .core_init(core_init)
  );

  panel_mem_seq #(.WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .go_load  (accept & quiet & fire[KEY_LOAD]),
    .go_dep   (accept & quiet & fire[KEY_DEP]),
    .go_exam  (accept & quiet & fire[KEY_EXAM]),
    .sw_reg   (sw_reg),
    .idle     (seq_idle),
    .pc       (pc),
    .req_valid(mem_req_valid),
    .req_ready(mem_req_ready),
    .req_write(mem_req_write),
    .req_addr (mem_req_addr),
    .req_wdata(mem_req_wdata),
    .rdata    (mem_rdata),
    .disp_addr(disp_addr),
    .disp_data(disp_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_mode <= 1'b0;
      inst_mode <= 1'b0;
    end else begin
      step_mode <= sw_step_raw ^ INVERT_MODES;
      inst_mode <= sw_inst_raw ^ INVERT_MODES;
    end
  end
endmodule

// File: rtl/panel_console_chk.sv
module panel_console_chk #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              core_init,
  input logic [WORD_W-1:0] pc,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [WORD_W-1:0] mem_req_addr,
  input logic [WORD_W-1:0] mem_req_wdata
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_write)));

  assert_pc_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> $stable(pc));

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready) |=> (pc == $past(mem_req_addr) + WORD_W'(1)));

  assert_init_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    core_init |=> !core_init);

  assert_init_runs_R8: assert property (@(posedge clk) disable iff (rst)
    core_init |-> run);

  assert_halted_access_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_valid) |-> !run);
endmodule

bind panel_console panel_console_chk #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .run          (run),
  .core_init    (core_init),
  .pc           (pc),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata)
);

// File: tb/panel_console_tb_top.sv
module panel_console_tb_top;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] sw_reg = '0;
  logic k_start = 0, k_load = 0, k_dep = 0, k_exam = 0, k_cont = 0, k_stop = 0;
  logic step_raw = 0, inst_raw = 0;
  logic step_mode, inst_mode, run, core_init;
  logic [W-1:0] pc, req_addr, req_wdata, disp_addr, disp_data;
  logic req_valid, req_write;
  logic ready = 1'b0;
  logic [W-1:0] rdata = '0;

  panel_console dut_i (
    .clk(clk), .rst(rst), .sw_reg(sw_reg),
    .key_start(k_start), .key_load(k_load), .key_dep(k_dep),
    .key_exam(k_exam), .key_cont(k_cont), .key_stop(k_stop),
    .sw_step_raw(step_raw), .sw_inst_raw(inst_raw),
    .step_mode(step_mode), .inst_mode(inst_mode),
    .run(run), .core_init(core_init), .pc(pc),
    .mem_req_valid(req_valid), .mem_req_ready(ready),
    .mem_req_write(req_write), .mem_req_addr(req_addr),
    .mem_req_wdata(req_wdata), .mem_rdata(rdata),
    .disp_addr(disp_addr), .disp_data(disp_data)
  );

  // Second instance: release-triggered deposit, inverted mode switches.
  logic [W-1:0] r_sw = '0;
  logic r_dep = 0;
  logic r_step, r_inst, r_run, r_init, r_valid, r_write;
  logic [W-1:0] r_pc, r_addr, r_wdata, r_daddr, r_ddata;

  panel_console #(.DEP_ON_RELEASE(1'b1), .INVERT_MODES(1'b1)) dut_rel_i (
    .clk(clk), .rst(rst), .sw_reg(r_sw),
    .key_start(1'b0), .key_load(1'b0), .key_dep(r_dep),
    .key_exam(1'b0), .key_cont(1'b0), .key_stop(1'b0),
    .sw_step_raw(step_raw), .sw_inst_raw(inst_raw),
    .step_mode(r_step), .inst_mode(r_inst),
    .run(r_run), .core_init(r_init), .pc(r_pc),
    .mem_req_valid(r_valid), .mem_req_ready(1'b1),
    .mem_req_write(r_write), .mem_req_addr(r_addr),
    .mem_req_wdata(r_wdata), .mem_rdata('0),
    .disp_addr(r_daddr), .disp_data(r_ddata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0o expected=%0o", req, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct { bit wr; logic [W-1:0] a; logic [W-1:0] d; } exp_t;
  exp_t q[$];
  logic [W-1:0] mem [int];
  int lat = 0;
  int wait_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ready) begin
        // handshake took place at the previous rising edge
        exp_t e;
        ready = 1'b0;
        wait_cnt = 0;
        if (q.size() == 0) begin
          chk(0, "R7 unexpected request", int'(req_addr), 0);
        end else begin
          e = q.pop_front();
          chk(req_write == e.wr, "R3/R4 request kind", int'(req_write), int'(e.wr));
          chk(req_addr == e.a, "R3/R4 request address", int'(req_addr), int'(e.a));
          if (e.wr) begin
            chk(req_wdata == e.d, "R3 write data", int'(req_wdata), int'(e.d));
            mem[int'(e.a)] = e.d;
          end else begin
            chk(disp_data == e.d, "R4 examined word on display", int'(disp_data), int'(e.d));
          end
          chk(pc == e.a + W'(1), "R5 pc after access", int'(pc), int'(e.a + W'(1)));
        end
      end else if (req_valid) begin
        if (wait_cnt >= lat) begin
          ready = 1'b1;
          rdata = mem.exists(int'(req_addr)) ? mem[int'(req_addr)] : '0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  task automatic press(input int k, input int hold);
    @(negedge clk); #1;
    case (k)
      0: k_start = 1; 1: k_load = 1; 2: k_dep = 1;
      3: k_exam = 1;  4: k_cont = 1; default: k_stop = 1;
    endcase
    repeat (hold) @(negedge clk);
    #1;
    k_start = 0; k_load = 0; k_dep = 0; k_exam = 0; k_cont = 0; k_stop = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      if (q.size() == 0 && !req_valid && !ready) break;
    end
  endtask

  task automatic load_addr(input logic [W-1:0] a);
    sw_reg = a;
    press(1, 1);
    chk(pc == a, "R2 load address", int'(pc), int'(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(run == 0, "R1 run", run, 0);
    chk(core_init == 0, "R1 core_init", core_init, 0);
    chk(req_valid == 0, "R1 valid", req_valid, 0);
    chk(pc == 0, "R1 pc", int'(pc), 0);
    chk(disp_addr == 0 && disp_data == 0, "R1 displays", int'(disp_addr), 0);

    // Deposit a run of words with varying latency and hold time (R3, R6)
    load_addr(12'o0100);
    for (int i = 0; i < 5; i++) begin
      exp_t e;
      lat = i % 3;
      sw_reg = 12'o1234 + W'(i * 12'o0111);
      e.wr = 1; e.a = 12'o0100 + W'(i); e.d = sw_reg;
      q.push_back(e);
      press(2, 1 + 3 * i);
      drain();
    end
    chk(pc == 12'o0105, "R5 pc after deposit run", int'(pc), 12'o0105);

    // Read them back (R4)
    load_addr(12'o0100);
    for (int i = 0; i < 5; i++) begin
      exp_t e;
      lat = 2 - (i % 3);
      e.wr = 0; e.a = 12'o0100 + W'(i); e.d = 12'o1234 + W'(i * 12'o0111);
      q.push_back(e);
      press(3, 2);
      drain();
    end
    chk(disp_addr == 12'o0104, "R4 address display", int'(disp_addr), 12'o0104);

    // Keys during an outstanding request are dropped (R7)
    load_addr(12'o0200);
    lat = 8;
    begin
      exp_t e;
      sw_reg = 12'o0707;
      e.wr = 1; e.a = 12'o0200; e.d = 12'o0707;
      q.push_back(e);
    end
    press(2, 1);
    sw_reg = 12'o0777;
    press(1, 1);
    press(3, 1);
    press(0, 1);
    drain();
    chk(pc == 12'o0201, "R7 pc unaffected by keys while busy", int'(pc), 12'o0201);
    chk(run == 0, "R7 start dropped while busy", run, 0);
    lat = 0;

    // Wrap (R5)
    load_addr(12'o7777);
    begin
      exp_t e;
      sw_reg = 12'o0042;
      e.wr = 1; e.a = 12'o7777; e.d = 12'o0042;
      q.push_back(e);
    end
    press(2, 1);
    drain();
    chk(pc == 0, "R5 wrap to zero", int'(pc), 0);

    // Start (R8)
    @(negedge clk); #1; k_start = 1;
    @(negedge clk); #1;
    chk(core_init == 1 && run == 1, "R8 start pulse and run", int'({core_init, run}), 3);
    @(negedge clk); #1;
    chk(core_init == 0, "R8 pulse one cycle", core_init, 0);
    k_start = 0;

    // Keys while running (R10)
    sw_reg = 12'o0333;
    press(1, 1);
    press(2, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(pc == 0, "R10 load ignored while running", int'(pc), 0);
    chk(req_valid == 0 && q.size() == 0, "R10 deposit ignored while running", req_valid, 0);
    press(5, 1);
    chk(run == 0, "R10 stop clears run", run, 0);

    // Continue (R9)
    @(negedge clk); #1; k_cont = 1;
    @(negedge clk); #1;
    chk(run == 1 && core_init == 0, "R9 continue", int'({run, core_init}), 2);
    k_cont = 0;
    press(5, 2);
    chk(run == 0, "R10 stop after continue", run, 0);

    // Polarity and release-triggered deposit (R11)
    @(negedge clk); #1; step_raw = 1; inst_raw = 0;
    @(negedge clk); #1;
    chk(step_mode == 1 && inst_mode == 0, "R11 modes normal", int'({step_mode, inst_mode}), 2);
    chk(r_step == 0 && r_inst == 1, "R11 modes inverted", int'({r_step, r_inst}), 1);
    r_sw = 12'o0055; r_dep = 1;
    @(negedge clk); #1;
    chk(r_valid == 0, "R11 no request on press", r_valid, 0);
    @(negedge clk); #1;
    r_dep = 0;
    @(negedge clk); #1;
    chk(r_valid == 1 && r_write == 1 && r_wdata == 12'o0055 && r_addr == 0,
        "R11 request on release", int'(r_wdata), 12'o0055);
    @(negedge clk); #1;
    chk(r_pc == 1 && r_valid == 0, "R11 release deposit completes", int'(r_pc), 1);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6 every expected request seen", q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule